// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software reach the management registers of an external Ethernet PHY through the two-wire MDC/MDIO management interface. Four 32-bit registers sit on a simple register bus. They are a control word, a command word, a data word and a status word. Software picks the clock divisor and the preamble mode in the control word. For a write, it loads the data word first. It then writes the command word with the operation, the PHY address and the register number, and polls the busy flag until it drops. After a read, the 16-bit result sits in the data word.

The controller builds the whole management frame and divides the system clock into MDC. It shifts the frame out MSB first, changing MDIO only while MDC is low, and samples the PHY's reply on the MDC rising edges. MDC stays low and the MDIO driver stays off whenever no transaction is running. A self-clearing soft reset aborts any frame in progress and returns all registers to their reset values.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After rst_ni the registers read as follows. Control (word index 0) is 0x0000_4E00, which is divisor field 39 with preamble suppression off and the reset bit clear. Command (index 1) is 0, data (index 2) is 0 and status (index 3) is 0. MDC and the MDIO output enable are both low.
- R2: In a command word, bit 15 requests a read, bit 14 requests a write, bits 9:5 give the PHY address and bits 4:0 the register number. If both bits 15 and 14 are set, the command is a read. A command with neither bit set is stored but starts no transaction.
- R3: A write frame drives 64 bits MSB first with the enable high throughout. The bits are 32 ones, then 01, then 01, then the PHY address, then the register number, then 10, then the 16-bit data word.
- R4: A read frame drives 32 ones, then 01, then 10, then the PHY address and the register number. The enable drops from the first turnaround bit onward. The 16 data bits that follow are sampled on MDC rising edges, and they appear in the data word once busy clears.
- R5: Control bit 8 set drops the 32 ones from the frame. A write then drives 32 bits and a read drives 14 bits, in a frame of 32 MDC periods.
- R6: Control bits 15:9 hold F = D-1, and a value of 0 acts as 1. MDC has a period of D system clocks: it is low for floor(D/2) clocks and high for the rest. At reset D is 40, which gives 2.5 MHz MDC from a 100 MHz clock. MDC is low whenever no transaction is running.
- R7: MDIO and its enable never change while MDC stays high. They change only at the start of each MDC low phase.
- R8: Status bit 0 rises on the clock edge that accepts a command. It falls exactly N*D clocks later, where N is 64, or 32 with the preamble suppressed.
- R9: While busy is set, writes to the command word, the data word and the divisor and preamble fields are ignored.
- R10: Writing control with bit 0 set aborts any frame, so MDC and the enable go low. It restores every register to its R1 value, and bit 0 reads 1 for RST_CYCLES (4) clocks before it clears itself. A command written during that window starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Register access strobe |
| bus_write_i | input | 1 | Access is a write |
| bus_addr_i | input | 2 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the indexed register, combinational |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Busy rises on the edge that takes the command and falls N*D clocks later. The bench times this from the falling clock edge after the command write to the first falling edge where the status reads idle, and compares the result with N*D. Each MDC period is timed between successive rising edges seen at falling clock edges. The pins are held stable across each high phase, and the PHY model sets its reply bit at the falling clock edge after each MDC rise, so the reply is ready well before the next sample. The frame bits and the read result are checked only after busy has cleared, two falling edges later. The soft reset bit is counted at each falling edge, starting at the one right after the write edge.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS  = 64;
  localparam int PRE_BITS    = 32;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int TA_IDX      = 46;
  localparam int DATA_IDX    = 48;
  localparam int FLD_W       = 5;
  localparam int DATA_W      = 16;
  localparam int CMD_RD_BIT  = 15;
  localparam int CMD_WR_BIT  = 14;
  localparam int CMD_PHY_LSB = 5;
  localparam int CMD_REG_LSB = 0;
  localparam int CTL_RST_BIT = 0;
  localparam int CTL_PRE_BIT = 8;
  localparam int CTL_DIV_LSB = 9;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic              rd;
    logic [FLD_W-1:0]  phy;
    logic [FLD_W-1:0]  regnum;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_field_i,
  output logic             rise_o,
  output logic             end_o
);
  logic [DIV_W-1:0] cnt_q, last_cnt, rise_cnt;

  always_comb begin
    last_cnt = (div_field_i == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_field_i;
    rise_cnt = DIV_W'(((({1'b0, last_cnt} + 1'b1) >> 1) - 1'b1));
  end

  assign rise_o = run_i && (cnt_q == rise_cnt);
  assign end_o  = run_i && (cnt_q == last_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || end_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              start_i,
  input  mdio_req_t         req_i,
  input  logic              pre_sup_i,
  input  logic              rise_i,
  input  logic              end_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic              done_rd_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] FIRST_SUP = IDX_W'(PRE_BITS);

  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic [IDX_W-1:0]      idx_q, nxt_idx, first_idx;
  logic                  rd_q;
  logic [13:0]           hdr;
  logic [17:0]           tail;
  logic                  last_bit;

  always_comb begin
    hdr       = {2'b01, (req_i.rd ? 2'b10 : 2'b01), req_i.phy, req_i.regnum};
    tail      = req_i.rd ? 18'h3FFFF : {2'b10, req_i.wdata};
    frame_d   = {{PRE_BITS{1'b1}}, hdr, tail};
    first_idx = pre_sup_i ? FIRST_SUP : '0;
    nxt_idx   = idx_q + 1'b1;
    last_bit  = (idx_q == LAST_IDX);
  end

  assign done_o    = busy_o && end_i && last_bit && !clear_i;
  assign done_rd_o = rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0; mdc_o <= 1'b0; mdio_o <= 1'b1; mdio_oe_o <= 1'b0;
      frame_q <= '0; idx_q <= '0; rd_q <= 1'b0; rx_o <= '0;
    end else if (clear_i) begin
      busy_o <= 1'b0; mdc_o <= 1'b0; mdio_o <= 1'b1; mdio_oe_o <= 1'b0;
      idx_q <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o    <= 1'b1;
        frame_q   <= frame_d;
        rd_q      <= req_i.rd;
        idx_q     <= first_idx;
        mdc_o     <= 1'b0;
        mdio_o    <= frame_d[LAST_IDX - first_idx];
        mdio_oe_o <= 1'b1;
      end
    end else begin
      if (rise_i) begin
        mdc_o <= 1'b1;
        if (rd_q && (idx_q >= IDX_W'(DATA_IDX))) rx_o <= {rx_o[DATA_W-2:0], mdio_i};
      end
      if (end_i) begin
        mdc_o <= 1'b0;
        if (last_bit) begin
          busy_o    <= 1'b0;
          mdio_o    <= 1'b1;
          mdio_oe_o <= 1'b0;
        end else begin
          idx_q     <= nxt_idx;
          mdio_o    <= frame_q[LAST_IDX - nxt_idx];
          mdio_oe_o <= !(rd_q && (nxt_idx >= IDX_W'(TA_IDX)));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int DIV_RESET  = 39,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  reg_sel_e          bus_sel_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              done_rd_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              start_o,
  output mdio_req_t         req_o,
  output logic              pre_sup_o,
  output logic [DIV_W-1:0]  div_field_o,
  output logic              soft_rst_o
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

  logic [RC_W-1:0]   rst_cnt_q;
  logic [31:0]       cmd_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_en, wr_ctrl, wr_cmd, wr_data;

  assign soft_rst_o = (rst_cnt_q != '0);
  assign wr_en   = bus_valid_i && bus_write_i && !soft_rst_o;
  assign wr_ctrl = wr_en && (bus_sel_i == SEL_CTRL);
  assign wr_cmd  = wr_en && (bus_sel_i == SEL_CMD) && !busy_i;
  assign wr_data = wr_en && (bus_sel_i == SEL_DATA) && !busy_i;

  assign start_o      = wr_cmd && (bus_wdata_i[CMD_RD_BIT] || bus_wdata_i[CMD_WR_BIT]);
  assign req_o.rd     = bus_wdata_i[CMD_RD_BIT];
  assign req_o.phy    = bus_wdata_i[CMD_PHY_LSB +: FLD_W];
  assign req_o.regnum = bus_wdata_i[CMD_REG_LSB +: FLD_W];
  assign req_o.wdata  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_cnt_q <= '0; cmd_q <= '0; data_q <= '0;
      div_field_o <= DIV_INIT; pre_sup_o <= 1'b0;
    end else if (soft_rst_o) begin
      rst_cnt_q <= rst_cnt_q - 1'b1;
      cmd_q <= '0; data_q <= '0;
      div_field_o <= DIV_INIT; pre_sup_o <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        if (bus_wdata_i[CTL_RST_BIT]) begin
          rst_cnt_q <= RC_W'(RST_CYCLES);
        end else if (!busy_i) begin
          div_field_o <= bus_wdata_i[CTL_DIV_LSB +: DIV_W];
          pre_sup_o   <= bus_wdata_i[CTL_PRE_BIT];
        end
      end
      if (wr_cmd)  cmd_q  <= bus_wdata_i;
      if (wr_data) data_q <= bus_wdata_i[DATA_W-1:0];
      if (done_i && done_rd_i) data_q <= rx_data_i;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_sel_i)
      SEL_CTRL: begin
        bus_rdata_o[CTL_DIV_LSB +: DIV_W] = div_field_o;
        bus_rdata_o[CTL_PRE_BIT]          = pre_sup_o;
        bus_rdata_o[CTL_RST_BIT]          = soft_rst_o;
      end
      SEL_CMD:  bus_rdata_o = cmd_q;
      SEL_DATA: bus_rdata_o[DATA_W-1:0] = data_q;
      SEL_STAT: bus_rdata_o[0] = busy_i;
      default:  bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W      = 7,
  parameter int DIV_RESET  = 39,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_valid_i,
  input  logic        bus_write_i,
  input  logic [1:0]  bus_addr_i,
  input  logic [31:0] bus_wdata_i,
  output logic [31:0] bus_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic              busy, soft_rst, start, pre_sup, rise, period_end, done, done_rd;
  logic [DIV_W-1:0]  div_field;
  logic [DATA_W-1:0] rx_data;
  mdio_req_t         req;

  mdio_reg_file #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i,
    .bus_sel_i(reg_sel_e'(bus_addr_i)), .bus_wdata_i, .bus_rdata_o,
    .busy_i(busy), .done_i(done), .done_rd_i(done_rd), .rx_data_i(rx_data),
    .start_o(start), .req_o(req), .pre_sup_o(pre_sup),
    .div_field_o(div_field), .soft_rst_o(soft_rst)
  );

  mdio_mdc_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(busy), .div_field_i(div_field),
    .rise_o(rise), .end_o(period_end)
  );

  mdio_frame_seq u_seq (
    .clk_i, .rst_ni, .clear_i(soft_rst), .start_i(start), .req_i(req),
    .pre_sup_i(pre_sup), .rise_i(rise), .end_i(period_end), .mdio_i,
    .busy_o(busy), .mdc_o, .mdio_o, .mdio_oe_o,
    .done_o(done), .done_rd_o(done_rd), .rx_o(rx_data)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic in_rst_i,
  input logic mdc_i,
  input logic mdio_i,
  input logic oe_i
);
  p_idle_pins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !oe_i));

  p_stable_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_i && $past(mdc_i)) |-> ($stable(mdio_i) && $stable(oe_i)));

  p_start_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (!mdc_i && oe_i));

  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_rst_i |=> !busy_i);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .in_rst_i(soft_rst),
  .mdc_i(mdc_o), .mdio_i(mdio_o), .oe_i(mdio_oe_o)
);

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_CTRL = 2'd0, A_CMD = 2'd1, A_DATA = 2'd2, A_STAT = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i = 1'b1;

  mdio_mgmt_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int n; logic [63:0] bits; string tag; } exp_t;
  exp_t exp_q[$];

  int n_vec = 0, n_bad = 0;
  int cyc = 0, rise_k = 0, last_rise = 0, cap_n = 0, cur_d = 40;
  logic [63:0] cap_bits = '0;
  logic [15:0] phy_resp = '0;
  bit pre_sup = 0, chk_req = 0;
  logic mdc_prev = 0, mdio_prev = 1, oe_prev = 0;
  longint t_start = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: serial capture, MDC timing, PHY reply, scoreboard compare
  always @(negedge clk) begin
    cyc++;
    if (chk_req) begin
      chk_req = 0;
      if (exp_q.size() == 0) check("scoreboard empty", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " frame bit count"}, 64'(cap_n), 64'(e.n));
        check({e.tag, " frame bits"}, cap_bits, e.bits);
      end
    end
    if (mdc && mdc_prev)
      check("R7 pins stable while MDC high", {62'b0, mdio_o, mdio_oe}, {62'b0, mdio_prev, oe_prev});
    if (mdc && !mdc_prev) begin
      int p;
      if (mdio_oe) begin cap_bits = {cap_bits[62:0], mdio_o}; cap_n++; end
      if (rise_k > 0) check("R6 MDC period", 64'(cyc - last_rise), 64'(cur_d));
      last_rise = cyc;
      p = rise_k + (pre_sup ? 32 : 0) + 1;
      if (p >= 48 && p <= 63) mdio_i = phy_resp[63-p];
      else if (p == 47)       mdio_i = 1'b0;
      else                    mdio_i = 1'b1;
      rise_k++;
    end
    mdc_prev = mdc; mdio_prev = mdio_o; oe_prev = mdio_oe;
  end

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic start_txn(input bit rd, input bit wr, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] wdat,
                           input logic [15:0] resp, input string tag);
    exp_t e;
    logic [13:0] hdr;
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg};
    if (!rd) bus_wr(A_DATA, {16'b0, wdat});
    if (rd) begin
      e.n = pre_sup ? 14 : 46;
      e.bits = pre_sup ? {50'b0, hdr} : {18'b0, 32'hFFFF_FFFF, hdr};
    end else begin
      e.n = pre_sup ? 32 : 64;
      e.bits = pre_sup ? {32'b0, hdr, 2'b10, wdat} : {32'hFFFF_FFFF, hdr, 2'b10, wdat};
    end
    e.tag = tag;
    exp_q.push_back(e);
    phy_resp = resp; cap_bits = '0; cap_n = 0; rise_k = 0; mdio_i = 1'b1;
    bus_wr(A_CMD, {16'b0, rd, wr, 4'b0, phy, rg});
    t_start = $time;
  endtask

  task automatic finish_txn(input bit rd, input logic [15:0] resp, input string tag);
    logic [31:0] d;
    longint el;
    rd_reg(A_STAT, d);
    while (d[0]) begin @(negedge clk); rd_reg(A_STAT, d); end
    el = ($time - 1 - t_start) / CLK_PERIOD;
    check({"R8 busy length ", tag}, 64'(el), 64'((pre_sup ? 32 : 64) * cur_d));
    chk_req = 1;
    @(negedge clk); @(negedge clk);
    if (rd) begin rd_reg(A_DATA, d); check({"R4 read result ", tag}, 64'(d), 64'(resp)); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_reg(A_CTRL, d); check("R1 ctrl", 64'(d), 64'h4E00);
    rd_reg(A_CMD, d);  check("R1 cmd", 64'(d), 0);
    rd_reg(A_DATA, d); check("R1 data", 64'(d), 0);
    rd_reg(A_STAT, d); check("R1 status", 64'(d), 0);
    check("R1 pins", {62'b0, mdc, mdio_oe}, 0);

    // R3/R6 write at default divisor 40
    cur_d = 40;
    start_txn(0, 1, 5'h11, 5'h03, 16'hA5C3, 16'h0, "R3 write D40");
    finish_txn(0, 16'h0, "R3 D40");

    // R6 small divisor
    bus_wr(A_CTRL, 32'd3 << 9); cur_d = 4;
    rd_reg(A_CTRL, d); check("R6 ctrl readback", 64'(d), 64'(32'd3 << 9));
    start_txn(1, 0, 5'h01, 5'h02, 16'h0, 16'h1234, "R4 read");
    finish_txn(1, 16'h1234, "R4 read");
    // R2 both op bits -> read
    start_txn(1, 1, 5'h1F, 5'h1E, 16'h0, 16'hBEEF, "R2 both bits read");
    finish_txn(1, 16'hBEEF, "R2 both");

    // R5 preamble suppression
    bus_wr(A_CTRL, (32'd3 << 9) | 32'h100); pre_sup = 1;
    start_txn(0, 1, 5'h0A, 5'h15, 16'h5A0F, 16'h0, "R5 write suppressed");
    finish_txn(0, 16'h0, "R5 write");
    start_txn(1, 0, 5'h15, 5'h0A, 16'h0, 16'h8001, "R5 read suppressed");
    finish_txn(1, 16'h8001, "R5 read");

    // R6 odd divisor and field 0
    bus_wr(A_CTRL, 32'd4 << 9); pre_sup = 0; cur_d = 5;
    start_txn(0, 1, 5'h02, 5'h04, 16'hFFFF, 16'h0, "R6 write D5");
    finish_txn(0, 16'h0, "R6 D5");
    bus_wr(A_CTRL, 32'd0); cur_d = 2;
    start_txn(1, 0, 5'h03, 5'h05, 16'h0, 16'h0001, "R6 read D2");
    finish_txn(1, 16'h0001, "R6 D2");

    // R2 no op bits: stored, no transaction
    bus_wr(A_CMD, 32'h0000_0123);
    rd_reg(A_STAT, d); check("R2 no-op status", 64'(d), 0);
    repeat (5) @(negedge clk);
    check("R2 no-op MDC idle", {63'b0, mdc}, 0);
    rd_reg(A_CMD, d); check("R2 no-op cmd stored", 64'(d), 64'h123);

    // R9 writes ignored while busy
    bus_wr(A_CTRL, 32'd3 << 9); cur_d = 4;
    start_txn(0, 1, 5'h07, 5'h08, 16'hC0DE, 16'h0, "R9 write");
    bus_wr(A_CMD, 32'h0000_80E0);
    bus_wr(A_DATA, 32'h0000_0F0F);
    bus_wr(A_CTRL, 32'd10 << 9);
    finish_txn(0, 16'h0, "R9");
    rd_reg(A_CMD, d);  check("R9 cmd unchanged", 64'(d), 64'(32'h0000_4000 | (32'h07 << 5) | 32'h08));
    rd_reg(A_DATA, d); check("R9 data unchanged", 64'(d), 64'hC0DE);
    rd_reg(A_CTRL, d); check("R9 ctrl unchanged", 64'(d), 64'(32'd3 << 9));

    // R10 soft reset aborts and self-clears
    start_txn(1, 0, 5'h09, 5'h0C, 16'h0, 16'h4321, "R10 aborted");
    repeat (20) @(negedge clk);
    bus_wr(A_CTRL, 32'h1);
    n = 0;
    rd_reg(A_CTRL, d);
    while (d[0] && n < 100) begin n++; @(negedge clk); rd_reg(A_CTRL, d); end
    check("R10 reset bit duration", 64'(n), 4);
    void'(exp_q.pop_back());
    pre_sup = 0; cur_d = 40;
    rd_reg(A_STAT, d); check("R10 busy cleared", 64'(d), 0);
    check("R10 pins idle", {62'b0, mdc, mdio_oe}, 0);
    rd_reg(A_CTRL, d); check("R10 ctrl default", 64'(d), 64'h4E00);
    rd_reg(A_CMD, d);  check("R10 cmd cleared", 64'(d), 0);
    rd_reg(A_DATA, d); check("R10 data cleared", 64'(d), 0);
    bus_wr(A_CTRL, 32'h1);
    bus_wr(A_CMD, 32'h0000_8021);
    rd_reg(A_STAT, d); check("R10 cmd during reset no start", 64'(d), 0);
    repeat (6) @(negedge clk);
    check("R10 MDC idle after", {62'b0, mdc, mdio_oe}, 0);

    // recovery after reset
    bus_wr(A_CTRL, 32'd3 << 9); cur_d = 4;
    start_txn(0, 1, 5'h1C, 5'h13, 16'h6B2D, 16'h0, "R3 write after reset");
    finish_txn(0, 16'h0, "R3 after reset");

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule